// File: doc/BRIEF.md
# MOESI Snooping Cache-Line Controller

This block is the per-core coherence controller for a small direct-mapped set of 64-byte cache lines. Each line carries its coherence state as four separate status flags (dirty, readable, writable, valid). Taken together as a nibble, these flags give the five MOESI states. The local processor presents reads, instruction fetches and writes on a request port. The controller answers hits itself. On a miss or a permission upgrade it issues a line-aligned bus request and waits for the response. A dirty victim is written back before the fill.

Requests from other caches reach the snoop port. The controller looks each one up and changes the line's state. One cycle later it reports three things: whether it held the line, whether it will supply the data, and whether memory must still serve the request. A dirty line that is snooped by a read passes into the owned state and keeps supplying data, so the memory access is suppressed. A write to a shared or owned line needs no data, only the other copies removed, so it sends a data-less upgrade.

The controller has four states, driven by the processor side:
- `CT_IDLE` accepts a request. It goes to `CT_EVICT` on a miss with a dirty victim, to `CT_FILL` on any other miss, and to `CT_UPGRADE` on a write hit to a non-writable line. Otherwise it stays in `CT_IDLE`.
- `CT_EVICT` issues the fill read and goes to `CT_FILL`.
- `CT_FILL` waits for the fill response. It then returns to `CT_IDLE`, or goes to `CT_UPGRADE` for a write whose fill arrived shared.
- `CT_UPGRADE` waits for the upgrade response, makes the line M and returns to `CT_IDLE`.

Top module: `moesi_line_ctrl`

## Requirements
- R1: `probe_state` gives the state of the line that `probe_addr` falls in, built as {dirty, readable, writable, valid}: I=0x0, S=0x5, E=0x7, O=0xD, M=0xF. A line whose tag does not match, or that is not valid, reads 0x0. All lines are I after reset.
- R2: Every bus request address is aligned to a 64-byte line, with bits [5:0] zero. Bus and snoop commands use 0 = dirty writeback, 1 = shared read, 2 = clean (instruction) read, 3 = upgrade.
- R3: A read miss issues a shared read, and an instruction-fetch read miss issues a clean read, one cycle after acceptance. The fill installs E when `rsp_shared`=0 and S when `rsp_shared`=1, with `req_done` one cycle after the response.
- R4: A read hit in S, E, O or M pulses `req_done` the cycle after acceptance, issues no bus request and leaves the state unchanged.
- R5: A write hit in E or M sets the line to M with `req_done` the next cycle and no bus request.
- R6: A write hit in S or O issues an upgrade the next cycle. The line becomes M, with `req_done`, only in the cycle after the upgrade response.
- R7: A write miss issues a shared read. A fill with `rsp_shared`=0 installs M directly. A fill with `rsp_shared`=1 is followed by an upgrade, then M.
- R8: A miss whose set holds a different line in M or O first issues a writeback of the victim's line address, then the fill read one cycle later. A victim in E or S is dropped without a writeback.
- R9: A snooped shared or clean read that hits M moves the line to O. A snooped read that hits O keeps O. Both answer with supply=1 and mem_needed=0.
- R10: A snooped read that hits E moves the line to S. A snooped read that hits S keeps S. Both answer with supply=0 and mem_needed=1.
- R11: A snooped upgrade that hits S or O invalidates the line (state 0x0).
- R12: A snoop that misses, or finds the line invalid, changes no state and answers hit=0 and supply=0. It answers mem_needed=1 for reads and 0 otherwise.
- R13: `snp_rsp_valid` pulses exactly one cycle after each `snp_valid`.
- R14: `req_ready` is high only in `CT_IDLE`. It is low while a fill or an upgrade is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_addr | input | ADDR_W | Processor byte address |
| req_ready | output | 1 | Controller can accept a request |
| req_done | output | 1 | Request completed (pulse) |
| bus_req_valid | output | 1 | Bus request issued (pulse) |
| bus_req_cmd | output | 2 | Bus command code |
| bus_req_addr | output | ADDR_W | Line-aligned bus address |
| rsp_valid | input | 1 | Response to the outstanding fill or upgrade |
| rsp_shared | input | 1 | Another cache holds the filled line |
| snp_valid | input | 1 | Snooped request present |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_rsp_valid | output | 1 | Snoop answer valid |
| snp_hit | output | 1 | Snooped line was held |
| snp_supply | output | 1 | This cache supplies the data |
| snp_mem_needed | output | 1 | Memory must serve the snooped read |
| probe_addr | input | ADDR_W | Address whose line state is reported |
| probe_state | output | 4 | State nibble of that line |

## Verification
The assertions assume that a response arrives only while a fill or an upgrade is outstanding. They also assume that no snoop targets the set of an outstanding processor request, and that no snooped upgrade hits a line held in E or M, since another cache cannot hold a shared copy to upgrade from. The bench meets these conditions by construction. It runs each processor request and each snoop to completion before starting the next. It answers the bus only in the cycle it expects a request. Any random snooped upgrade that would hit an E or M line in its reference model becomes a shared read instead.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef struct packed {
        logic dirty;
        logic readable;
        logic writable;
        logic valid;
    } mflags_t;

    localparam mflags_t LS_I = 4'h0;
    localparam mflags_t LS_S = 4'h5;
    localparam mflags_t LS_E = 4'h7;
    localparam mflags_t LS_O = 4'hD;
    localparam mflags_t LS_M = 4'hF;

    typedef enum logic [1:0] {
        BUS_WRBACK    = 2'd0,
        BUS_RD_SHARED = 2'd1,
        BUS_RD_CLEAN  = 2'd2,
        BUS_UPGRADE   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_EVICT,
        CT_FILL,
        CT_UPGRADE
    } ctrl_state_e;

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 24,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p_we,
    input  logic [IDX_W-1:0] p_idx,
    input  logic [TAG_W-1:0] p_tag,
    input  mflags_t          p_st,
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_idx,
    input  mflags_t          s_st,
    output logic [TAG_W-1:0] tag_q [NUM_LINES],
    output mflags_t          st_q  [NUM_LINES]
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[i] <= '1;
                st_q[i]  <= LS_I;
            end else if (p_we && p_idx == IDX_W'(i)) begin
                tag_q[i] <= p_tag;
                st_q[i]  <= p_st;
            end else if (s_we && s_idx == IDX_W'(i)) begin
                st_q[i] <= s_st;
                if (!s_st.valid) begin
                    tag_q[i] <= '1;
                end
            end
        end
    end

endmodule

// File: rtl/moesi_snoop_decide.sv
module moesi_snoop_decide
    import moesi_pkg::*;
(
    input  logic       hit,
    input  mflags_t    cur,
    input  logic [1:0] cmd,
    output mflags_t    nxt,
    output logic       upd,
    output logic       supply,
    output logic       mem_needed
);

    logic is_read;

    always_comb begin
        is_read = (cmd == BUS_RD_SHARED) || (cmd == BUS_RD_CLEAN);
        nxt     = cur;
        upd     = 1'b0;
        supply  = 1'b0;
        if (hit) begin
            if (is_read) begin
                upd    = 1'b1;
                supply = cur.dirty;
                nxt    = cur.dirty ? LS_O : LS_S;
            end else if (cmd == BUS_UPGRADE) begin
                upd = 1'b1;
                nxt = LS_I;
            end
        end
        mem_needed = is_read && !supply;
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_LINES  = 4,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_ifetch,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              req_done,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              rsp_valid,
    input  logic              rsp_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_rsp_valid,
    output logic              snp_hit,
    output logic              snp_supply,
    output logic              snp_mem_needed,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [3:0]        probe_state
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    ctrl_state_e fsm_q, fsm_nx;

    logic [TAG_W-1:0] tag_q [NUM_LINES];
    mflags_t          st_q  [NUM_LINES];

    // latched request
    logic             pend_write, pend_ifetch;
    logic [IDX_W-1:0] pend_idx;
    logic [TAG_W-1:0] pend_tag;

    // processor-side lookup
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    mflags_t          lk_st;
    logic             lk_hit;

    // actions decided this cycle
    logic             p_we, latch, done_nx, breq_nx;
    mflags_t          p_st;
    bus_cmd_e         bcmd_nx;
    logic [ADDR_W-1:0] baddr_nx;
    bus_cmd_e         fill_cmd;

    // snoop side
    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    logic             s_hit, s_upd, s_supply, s_memn;
    mflags_t          s_nxt;

    // probe
    logic [IDX_W-1:0] pr_idx;
    logic [TAG_W-1:0] pr_tag;

    moesi_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .p_we  (p_we),
        .p_idx (lk_idx),
        .p_tag (lk_tag),
        .p_st  (p_st),
        .s_we  (snp_valid && s_upd),
        .s_idx (s_idx),
        .s_st  (s_nxt),
        .tag_q (tag_q),
        .st_q  (st_q)
    );

    assign s_idx = snp_addr[OFF_W +: IDX_W];
    assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
    assign s_hit = snp_valid && st_q[s_idx].valid && (tag_q[s_idx] == s_tag);

    moesi_snoop_decide u_snoop (
        .hit        (s_hit),
        .cur        (st_q[s_idx]),
        .cmd        (snp_cmd),
        .nxt        (s_nxt),
        .upd        (s_upd),
        .supply     (s_supply),
        .mem_needed (s_memn)
    );

    assign pr_idx      = probe_addr[OFF_W +: IDX_W];
    assign pr_tag      = probe_addr[ADDR_W-1 -: TAG_W];
    assign probe_state = (st_q[pr_idx].valid && tag_q[pr_idx] == pr_tag) ? st_q[pr_idx] : LS_I;

    assign req_ready = (fsm_q == CT_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= CT_IDLE;
        else        fsm_q <= fsm_nx;
    end

    // next state and actions
    always_comb begin
        lk_idx   = (fsm_q == CT_IDLE) ? req_addr[OFF_W +: IDX_W] : pend_idx;
        lk_tag   = (fsm_q == CT_IDLE) ? req_addr[ADDR_W-1 -: TAG_W] : pend_tag;
        lk_st    = st_q[lk_idx];
        lk_hit   = lk_st.valid && (tag_q[lk_idx] == lk_tag);
        fill_cmd = ((fsm_q == CT_IDLE) ? (req_ifetch && !req_write) : (pend_ifetch && !pend_write))
                   ? BUS_RD_CLEAN : BUS_RD_SHARED;
        fsm_nx   = fsm_q;
        p_we     = 1'b0;
        p_st     = LS_I;
        latch    = 1'b0;
        done_nx  = 1'b0;
        breq_nx  = 1'b0;
        bcmd_nx  = BUS_WRBACK;
        baddr_nx = {lk_tag, lk_idx, {OFF_W{1'b0}}};
        unique case (fsm_q)
            CT_IDLE: begin
                if (req_valid) begin
                    latch = 1'b1;
                    if (lk_hit && !req_write) begin
                        done_nx = 1'b1;
                    end else if (lk_hit && lk_st.writable) begin
                        p_we    = 1'b1;
                        p_st    = LS_M;
                        done_nx = 1'b1;
                    end else if (lk_hit) begin
                        breq_nx = 1'b1;
                        bcmd_nx = BUS_UPGRADE;
                        fsm_nx  = CT_UPGRADE;
                    end else if (lk_st.valid && lk_st.dirty) begin
                        breq_nx  = 1'b1;
                        bcmd_nx  = BUS_WRBACK;
                        baddr_nx = {tag_q[lk_idx], lk_idx, {OFF_W{1'b0}}};
                        p_we     = 1'b1;
                        p_st     = LS_I;
                        fsm_nx   = CT_EVICT;
                    end else begin
                        breq_nx = 1'b1;
                        bcmd_nx = fill_cmd;
                        fsm_nx  = CT_FILL;
                    end
                end
            end
            CT_EVICT: begin
                breq_nx = 1'b1;
                bcmd_nx = fill_cmd;
                fsm_nx  = CT_FILL;
            end
            CT_FILL: begin
                if (rsp_valid) begin
                    p_we = 1'b1;
                    if (!pend_write) begin
                        p_st    = rsp_shared ? LS_S : LS_E;
                        done_nx = 1'b1;
                        fsm_nx  = CT_IDLE;
                    end else if (!rsp_shared) begin
                        p_st    = LS_M;
                        done_nx = 1'b1;
                        fsm_nx  = CT_IDLE;
                    end else begin
                        p_st    = LS_S;
                        breq_nx = 1'b1;
                        bcmd_nx = BUS_UPGRADE;
                        fsm_nx  = CT_UPGRADE;
                    end
                end
            end
            CT_UPGRADE: begin
                if (rsp_valid) begin
                    p_we    = 1'b1;
                    p_st    = LS_M;
                    done_nx = 1'b1;
                    fsm_nx  = CT_IDLE;
                end
            end
            default: fsm_nx = CT_IDLE;
        endcase
    end

    // registered outputs and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_done       <= 1'b0;
            bus_req_valid  <= 1'b0;
            bus_req_cmd    <= 2'd0;
            bus_req_addr   <= '0;
            snp_rsp_valid  <= 1'b0;
            snp_hit        <= 1'b0;
            snp_supply     <= 1'b0;
            snp_mem_needed <= 1'b0;
            pend_write     <= 1'b0;
            pend_ifetch    <= 1'b0;
            pend_idx       <= '0;
            pend_tag       <= '0;
        end else begin
            req_done       <= done_nx;
            bus_req_valid  <= breq_nx;
            bus_req_cmd    <= bcmd_nx;
            bus_req_addr   <= baddr_nx;
            snp_rsp_valid  <= snp_valid;
            snp_hit        <= s_hit;
            snp_supply     <= s_supply;
            snp_mem_needed <= snp_valid && s_memn;
            if (latch) begin
                pend_write  <= req_write;
                pend_ifetch <= req_ifetch;
                pend_idx    <= lk_idx;
                pend_tag    <= lk_tag;
            end
        end
    end

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_done,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              snp_valid,
    input logic              snp_rsp_valid,
    input logic              snp_supply,
    input logic              snp_mem_needed,
    input logic [3:0]        probe_state
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_addr[OFF_W-1:0] == '0));

    assert_upgrade_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == 2'd3) |-> !req_ready);

    assert_supply_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_rsp_valid && snp_supply) |-> !snp_mem_needed);

    assert_snoop_answer_R13: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_rsp_valid);

    assert_no_spurious_answer_R13: assert property (@(posedge clk) disable iff (!rst_n)
        snp_rsp_valid |-> $past(snp_valid));

    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_state == 4'h0 || probe_state == 4'h5 || probe_state == 4'h7 ||
         probe_state == 4'hD || probe_state == 4'hF));

    assert_done_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> req_ready);

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .req_done       (req_done),
    .bus_req_valid  (bus_req_valid),
    .bus_req_cmd    (bus_req_cmd),
    .bus_req_addr   (bus_req_addr),
    .snp_valid      (snp_valid),
    .snp_rsp_valid  (snp_rsp_valid),
    .snp_supply     (snp_supply),
    .snp_mem_needed (snp_mem_needed),
    .probe_state    (probe_state)
);

// File: tb/moesi_line_ctrl_bench.sv
module moesi_line_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_ifetch = 0;
    logic [31:0] req_addr = 0;
    logic        req_ready, req_done, bus_req_valid;
    logic [1:0]  bus_req_cmd;
    logic [31:0] bus_req_addr;
    logic        rsp_valid = 0, rsp_shared = 0;
    logic        snp_valid = 0;
    logic [1:0]  snp_cmd = 0;
    logic [31:0] snp_addr = 0;
    logic        snp_rsp_valid, snp_hit, snp_supply, snp_mem_needed;
    logic [31:0] probe_addr = 0;
    logic [3:0]  probe_state;

    int n_chk = 0;
    int n_bad = 0;

    logic [23:0] m_tag [4];
    logic [3:0]  m_st  [4];

    always #10 clk = ~clk;

    moesi_line_ctrl u_moesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_ifetch(req_ifetch), .req_addr(req_addr),
        .req_ready(req_ready), .req_done(req_done),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
        .rsp_valid(rsp_valid), .rsp_shared(rsp_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_rsp_valid(snp_rsp_valid), .snp_hit(snp_hit), .snp_supply(snp_supply),
        .snp_mem_needed(snp_mem_needed),
        .probe_addr(probe_addr), .probe_state(probe_state)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] mstate(input logic [31:0] a);
        logic [1:0] i = a[7:6];
        return (m_st[i][0] && m_tag[i] == a[31:8]) ? m_st[i] : 4'h0;
    endfunction

    task automatic probe(input logic [31:0] a);
        probe_addr = a;
        #1;
        chk("R1 probe state", probe_state, mstate(a));
    endtask

    task automatic respond(input logic shr);
        rsp_valid  = 1'b1;
        rsp_shared = shr;
        @(negedge clk);
        rsp_valid  = 1'b0;
    endtask

    task automatic do_proc(input logic wr, input logic ifq, input logic [31:0] a, input logic shr);
        logic [1:0]  i    = a[7:6];
        logic [3:0]  cur  = mstate(a);
        logic [31:0] line = {a[31:6], 6'd0};
        logic [3:0]  vic  = m_st[i];
        @(negedge clk);
        chk("R14 ready in idle", req_ready, 1);
        req_valid = 1; req_write = wr; req_ifetch = ifq; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        if (cur != 0) begin
            if (!wr) begin
                chk("R4 read hit done", req_done, 1);
                chk("R4 read hit no bus", bus_req_valid, 0);
            end else if (cur[1]) begin
                chk("R5 silent write done", req_done, 1);
                chk("R5 silent write no bus", bus_req_valid, 0);
                m_st[i] = 4'hF;
            end else begin
                chk("R6 upgrade issued", {bus_req_valid, bus_req_cmd}, {1'b1, 2'd3});
                chk("R6 upgrade addr", bus_req_addr, line);
                chk("R14 busy during upgrade", req_ready, 0);
                chk("R6 no early done", req_done, 0);
                respond(0);
                chk("R6 done after upgrade rsp", req_done, 1);
                m_st[i] = 4'hF;
            end
        end else begin
            if (vic[0] && vic[3]) begin
                chk("R8 writeback cmd", {bus_req_valid, bus_req_cmd}, {1'b1, 2'd0});
                chk("R8 writeback addr", bus_req_addr, {m_tag[i], i, 6'd0});
                m_st[i] = 4'h0;
                @(negedge clk);
            end
            chk(vic[0] ? "R8 fill after victim" : (wr ? "R7 write miss read" : "R3 miss read cmd"),
                {bus_req_valid, bus_req_cmd}, {1'b1, (!wr && ifq) ? 2'd2 : 2'd1});
            chk("R2 fill addr aligned", bus_req_addr, line);
            chk("R14 busy during fill", req_ready, 0);
            respond(shr);
            m_tag[i] = a[31:8];
            if (!wr) begin
                chk("R3 fill done", req_done, 1);
                m_st[i] = shr ? 4'h5 : 4'h7;
            end else if (!shr) begin
                chk("R7 write fill done", req_done, 1);
                m_st[i] = 4'hF;
            end else begin
                chk("R7 shared fill upgrade", {bus_req_valid, bus_req_cmd}, {1'b1, 2'd3});
                chk("R7 no early done", req_done, 0);
                respond(0);
                chk("R7 done after upgrade", req_done, 1);
                m_st[i] = 4'hF;
            end
        end
        probe(a);
    endtask

    task automatic do_snoop(input logic [1:0] cmd, input logic [31:0] a);
        logic [1:0] i    = a[7:6];
        logic [3:0] cur  = mstate(a);
        logic       hit  = (cur != 0);
        logic       rd   = (cmd == 2'd1 || cmd == 2'd2);
        logic       sup  = hit && rd && cur[3];
        string      r;
        r = !hit ? "R12" : (cmd == 2'd3 ? "R11" : (cur[3] ? "R9" : "R10"));
        @(negedge clk);
        snp_valid = 1; snp_cmd = cmd; snp_addr = a;
        @(negedge clk);
        snp_valid = 0;
        chk("R13 snoop answer", snp_rsp_valid, 1);
        chk({r, " snoop hit"}, snp_hit, hit);
        chk({r, " snoop supply"}, snp_supply, sup);
        chk({r, " snoop mem_needed"}, snp_mem_needed, rd && !sup);
        if (hit && rd)              m_st[i] = cur[3] ? 4'hD : 4'h5;
        if (hit && cmd == 2'd3)     m_st[i] = 4'h0;
        probe(a);
        @(negedge clk);
        chk("R13 answer is one pulse", snp_rsp_valid, 0);
    endtask

    function automatic logic [31:0] mk(input int t, input int i, input int o);
        return (32'(t) << 8) | (32'(i) << 6) | 32'(o);
    endfunction

    initial begin
        for (int k = 0; k < 4; k++) begin m_tag[k] = '1; m_st[k] = 0; end
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14 ready after reset", req_ready, 1);
        chk("R2 no bus after reset", bus_req_valid, 0);
        probe(mk(1, 0, 0));
        probe(mk(0, 3, 5));
        // directed corner cases
        do_proc(0, 0, mk(1, 0, 8), 0);    // R3 miss from memory -> E
        do_proc(1, 0, mk(1, 0, 12), 0);   // R5 E -> M silently
        do_proc(0, 0, mk(1, 0, 0), 0);    // R4 hit in M
        do_snoop(2'd1, mk(1, 0, 0));      // R9 M -> O, supply
        do_proc(0, 0, mk(1, 0, 4), 0);    // R4 read hit in O
        do_proc(1, 0, mk(1, 0, 4), 0);    // R6 write hit in O -> upgrade
        do_snoop(2'd2, mk(1, 0, 0));      // R9 clean read on M -> O
        do_snoop(2'd1, mk(1, 0, 0));      // R9 O stays O
        do_snoop(2'd3, mk(1, 0, 0));      // R11 O -> I
        do_proc(0, 1, mk(2, 1, 60), 1);   // R3 ifetch clean read -> S
        do_snoop(2'd1, mk(2, 1, 0));      // R10 S stays S
        do_proc(1, 0, mk(2, 1, 0), 0);    // R6 S -> upgrade -> M
        do_proc(0, 0, mk(3, 1, 0), 0);    // R8 dirty victim writeback
        do_snoop(2'd1, mk(3, 1, 0));      // R10 E -> S
        do_proc(0, 0, mk(4, 1, 0), 0);    // R8 clean victim dropped
        do_proc(1, 0, mk(5, 2, 3), 0);    // R7 write miss unshared
        do_proc(1, 0, mk(6, 3, 3), 1);    // R7 write miss shared
        do_snoop(2'd1, mk(9, 3, 0));      // R12 snoop miss
        do_snoop(2'd3, mk(9, 2, 0));      // R12 upgrade miss
        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a = mk($urandom % 3, $urandom % 4, $urandom % 64);
            int op = $urandom % 5;
            if (op < 3) begin
                do_proc(op == 1, op == 2, a, 1'($urandom % 2));
            end else begin
                logic [1:0] c = 2'($urandom % 4);
                if (c == 2'd3 && (mstate(a) == 4'h7 || mstate(a) == 4'hF)) c = 2'd1;
                do_snoop(c, a);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule